// File: doc/BRIEF.md
# Output-Port Flit Tag Remapper

This block sits on one output link of a five-port mesh router. Every flit bound for that link carries a small local message tag that is meaningful only on the link it arrived on. Before the flit leaves, the block gives it a tag that is unique on the outgoing link. That lets flits of different messages interleave on one set of wires.

When a header flit is accepted, the lowest-numbered free entry of a slot table is claimed. The entry records the input port and the incoming tag, and the entry index becomes the outgoing tag. Body and tail flits are matched on the pair (input port, incoming tag) and leave with the index of the matching entry. A tail flit frees its entry after it has been relabelled. The block exports the number of free entries to adaptive routing logic in neighbouring ports. A header that finds the table full is held by deasserting ready.

Top module: `flit_tag_remap`

## Requirements
- R1: A flit is laid out as type in bits [37:35], tag in bits [34:32] and data in bits [31:0] (default widths). Type 1 is header, type 2 is body and type 3 is tail. A flit of any other type is accepted and forwarded unchanged, and it leaves the table untouched.
- R2: An accepted flit appears on `out_flit_o` with `out_valid_o` high exactly one clock later, with its type and data unchanged. A cycle with no accepted flit gives `out_valid_o` low one clock later.
- R3: An accepted header claims the lowest-numbered free slot and leaves with that slot index as its tag.
- R4: A body flit whose input port and tag match an occupied slot leaves with that slot's index as its tag.
- R5: A tail flit is relabelled the same way as a body flit, and its slot becomes free at the same edge. A header accepted in the next cycle can reuse that slot.
- R6: While no slot is free and a header is presented, `in_ready_o` is low and the header is neither consumed nor forwarded. Body and tail flits are still accepted.
- R7: A body or tail flit that matches no occupied slot is forwarded unchanged and sets `err_o`, which stays high until reset.
- R8: After reset all slots are free: `free_cnt_o` equals the slot count, `out_valid_o` and `err_o` are low, and `in_ready_o` is high.
- R9: `free_cnt_o` gives the number of free slots. It drops by one for each accepted header, rises by one for each matched tail, and is otherwise stable.
- R10: Equal incoming tags arriving on different input ports belong to different messages and get different outgoing tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Flit offered by the crossbar |
| in_ready_o | output | 1 | Flit can be taken; low only when a header finds no free slot |
| in_port_i | input | 3 | Input port the flit came from (0 to 4) |
| in_flit_i | input | 38 | Incoming flit {type, tag, data} |
| out_valid_o | output | 1 | Relabelled flit valid on the link |
| out_flit_o | output | 38 | Relabelled flit {type, new tag, data} |
| free_cnt_o | output | 4 | Number of free slots |
| err_o | output | 1 | Sticky: a body or tail flit matched no slot |

## Verification
The assertions assume that a header never arrives for an (input port, tag) pair that already holds an open slot. They also assume that the type field of `in_flit_i` is meaningful even while `in_valid_i` is low, because ready is derived from it. The bench opens each message with a fresh pair, closes it with exactly one tail, and keeps the last flit's fields on the bus while idle. The one deliberate breach of the protocol is a body flit for an unopened pair, which is sent to exercise the error path.

// File: rtl/flit_tag_pkg.sv
package flit_tag_pkg;
  localparam int TYPE_W = 3;
  localparam logic [TYPE_W-1:0] FT_HEAD = 3'd1;
  localparam logic [TYPE_W-1:0] FT_BODY = 3'd2;
  localparam logic [TYPE_W-1:0] FT_TAIL = 3'd3;
endpackage

// File: rtl/free_slot_pick.sv
module free_slot_pick #(
  parameter int SLOTS = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic [SLOTS-1:0] busy_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0] free_cnt_o
);
  // lowest free wins: scan downward so the last write is the lowest index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    free_cnt_o = '0;
    for (int i = 0; i < SLOTS; i++)
      free_cnt_o = free_cnt_o + CNT_W'(!busy_i[i]);
  end
endmodule

// File: rtl/tag_slot_table.sv
module tag_slot_table #(
  parameter int SLOTS  = 8,
  parameter int TAG_W  = 3,
  parameter int PORT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] look_port_i,
  input  logic [TAG_W-1:0]  look_tag_i,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  alloc_idx_i,
  input  logic              rel_i,
  input  logic [TAG_W-1:0]  rel_idx_i,
  output logic [SLOTS-1:0]  busy_o,
  output logic              hit_o,
  output logic [TAG_W-1:0]  hit_idx_o
);
  logic [SLOTS-1:0] match;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              busy_q;
    logic [PORT_W-1:0] port_q;
    logic [TAG_W-1:0]  tag_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q <= 1'b0;
        port_q <= '0;
        tag_q  <= '0;
      end else if (alloc_i && alloc_idx_i == TAG_W'(s)) begin
        busy_q <= 1'b1;
        port_q <= look_port_i;
        tag_q  <= look_tag_i;
      end else if (rel_i && rel_idx_i == TAG_W'(s)) begin
        busy_q <= 1'b0;
      end
    end

    assign busy_o[s] = busy_q;
    assign match[s]  = busy_q && port_q == look_port_i && tag_q == look_tag_i;
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o     = 1'b1;
        hit_idx_o = TAG_W'(i);
      end
    end
  end
endmodule

// File: rtl/flit_tag_remap.sv
module flit_tag_remap
  import flit_tag_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32,
  parameter int PORTS  = 5,
  localparam int SLOTS  = 1 << TAG_W,
  localparam int PORT_W = $clog2(PORTS),
  localparam int CNT_W  = TAG_W + 1,
  localparam int FLIT_W = TYPE_W + TAG_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [PORT_W-1:0] in_port_i,
  input  logic [FLIT_W-1:0] in_flit_i,
  output logic              out_valid_o,
  output logic [FLIT_W-1:0] out_flit_o,
  output logic [CNT_W-1:0]  free_cnt_o,
  output logic              err_o
);
  logic [TYPE_W-1:0] f_type;
  logic [TAG_W-1:0]  f_tag;
  logic [DATA_W-1:0] f_data;
  assign {f_type, f_tag, f_data} = in_flit_i;

  logic is_head, is_tail, is_follow;
  assign is_head   = f_type == FT_HEAD;
  assign is_tail   = f_type == FT_TAIL;
  assign is_follow = f_type == FT_BODY || is_tail;

  logic [SLOTS-1:0] busy;
  logic             found, hit;
  logic [TAG_W-1:0] free_idx, hit_idx;

  free_slot_pick #(.SLOTS(SLOTS), .IDX_W(TAG_W), .CNT_W(CNT_W)) u_pick (
    .busy_i     (busy),
    .found_o    (found),
    .idx_o      (free_idx),
    .free_cnt_o (free_cnt_o)
  );

  logic accept;
  assign in_ready_o = !(is_head && !found);
  assign accept     = in_valid_i && in_ready_o;

  tag_slot_table #(.SLOTS(SLOTS), .TAG_W(TAG_W), .PORT_W(PORT_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .look_port_i (in_port_i),
    .look_tag_i  (f_tag),
    .alloc_i     (accept && is_head),
    .alloc_idx_i (free_idx),
    .rel_i       (accept && is_tail && hit),
    .rel_idx_i   (hit_idx),
    .busy_o      (busy),
    .hit_o       (hit),
    .hit_idx_o   (hit_idx)
  );

  logic [TAG_W-1:0] new_tag;
  always_comb begin
    new_tag = f_tag;
    if (is_head)               new_tag = free_idx;
    else if (is_follow && hit) new_tag = hit_idx;
  end

  // one link register: the only added latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_flit_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      out_valid_o <= accept;
      if (accept) out_flit_o <= {f_type, new_tag, f_data};
      if (accept && is_follow && !hit) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/flit_tag_remap_chk.sv
module flit_tag_remap_chk
  import flit_tag_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32,
  localparam int SLOTS  = 1 << TAG_W,
  localparam int CNT_W  = TAG_W + 1,
  localparam int FLIT_W = TYPE_W + TAG_W + DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [FLIT_W-1:0] in_flit_i,
  input logic              out_valid_o,
  input logic [FLIT_W-1:0] out_flit_o,
  input logic [CNT_W-1:0]  free_cnt_o,
  input logic              err_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);

  logic acc, acc_head;
  assign acc      = in_valid_i && in_ready_o;
  assign acc_head = acc && in_flit_i[FLIT_W-1 -: TYPE_W] == FT_HEAD;

  // R2
  out_follows_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o);
  // R2
  idle_gives_no_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !out_valid_o);
  // R2
  type_data_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (out_flit_o[FLIT_W-1 -: TYPE_W] == $past(in_flit_i[FLIT_W-1 -: TYPE_W])
             && out_flit_o[DATA_W-1:0] == $past(in_flit_i[DATA_W-1:0])));
  // R3
  empty_head_gets_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_head && free_cnt_o == FULL) |=> out_flit_o[DATA_W +: TAG_W] == '0);
  // R9
  head_takes_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_head |=> free_cnt_o == $past(free_cnt_o) - ONE);
  // R9
  idle_count_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> $stable(free_cnt_o));
  // R6
  stall_only_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> (free_cnt_o == '0 && in_flit_i[FLIT_W-1 -: TYPE_W] == FT_HEAD));
  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind flit_tag_remap flit_tag_remap_chk #(.TAG_W(TAG_W), .DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_flit_i   (in_flit_i),
  .out_valid_o (out_valid_o),
  .out_flit_o  (out_flit_o),
  .free_cnt_o  (free_cnt_o),
  .err_o       (err_o)
);

// File: tb/flit_tag_remap_tb_top.sv
`timescale 1ns/1ps
module flit_tag_remap_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [2:0]  in_port_i = '0;
  logic [37:0] in_flit_i = '0;
  logic        out_valid_o;
  logic [37:0] out_flit_o;
  logic [3:0]  free_cnt_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  flit_tag_remap dut_i (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_port_i, .in_flit_i,
    .out_valid_o, .out_flit_o, .free_cnt_o, .err_o
  );

  function automatic logic [37:0] mk(input logic [2:0] ty, input logic [2:0] tg,
                                     input logic [31:0] d);
    return {ty, tg, d};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at posedge+1; returns at posedge+1 of the next cycle
  task automatic send(input string req, input logic [2:0] port, input logic [2:0] ty,
                      input logic [2:0] tg, input logic [31:0] d, input logic [2:0] exp_tag);
    in_port_i  = port;
    in_flit_i  = mk(ty, tg, d);
    in_valid_i = 1'b1;
    #1 check({req, " ready"}, in_ready_o, 1);
    @(posedge clk_i); #1;
    in_valid_i = 1'b0;
    check({req, " valid"}, out_valid_o, 1);
    check({req, " flit"}, out_flit_o, mk(ty, exp_tag, d));
  endtask

  task automatic t_reset;
    check("R8 free", free_cnt_o, 8);
    check("R8 out_valid", out_valid_o, 0);
    check("R8 err", err_o, 0);
    check("R8 ready", in_ready_o, 1);
  endtask

  task automatic t_alloc;
    send("R3 head p0", 0, 1, 1, 32'hA000_0001, 0);
    send("R10 head p1 same tag", 1, 1, 1, 32'hB000_0001, 1);
    check("R9 after two heads", free_cnt_o, 6);
    send("R4 body p1", 1, 2, 1, 32'hB000_0002, 1);
    send("R4 body p0", 0, 2, 1, 32'hA000_0002, 0);
    @(posedge clk_i); #1;
    check("R2 idle out_valid", out_valid_o, 0);
  endtask

  task automatic t_release;
    send("R5 tail p0", 0, 3, 1, 32'hA000_0003, 0);
    check("R5 R9 free after tail", free_cnt_o, 7);
    send("R5 head reuses slot0", 2, 1, 5, 32'hC000_0001, 0);
    check("R9 after reuse", free_cnt_o, 6);
  endtask

  task automatic t_full;
    for (int i = 0; i < 6; i++)
      send("R3 fill", 3, 1, 3'(i), 32'hD000_0000 + i, 3'(i + 2));
    check("R9 full", free_cnt_o, 0);
    in_port_i  = 4;
    in_flit_i  = mk(1, 0, 32'hE000_0001);
    in_valid_i = 1'b1;
    #1 check("R6 ready low", in_ready_o, 0);
    @(posedge clk_i); #1;
    check("R6 no out", out_valid_o, 0);
    check("R6 count held", free_cnt_o, 0);
    in_valid_i = 1'b0;
    send("R6 body while full", 3, 2, 2, 32'hD000_0022, 4);
    send("R5 tail while full", 3, 3, 0, 32'hD000_0033, 2);
    check("R9 one free", free_cnt_o, 1);
    send("R6 stalled head retried", 4, 1, 0, 32'hE000_0001, 2);
    check("R9 full again", free_cnt_o, 0);
  endtask

  task automatic t_error;
    check("R7 err before", err_o, 0);
    send("R7 unmatched body", 4, 2, 7, 32'hF000_0007, 7);
    check("R7 err set", err_o, 1);
    check("R7 count held", free_cnt_o, 0);
    send("R1 unknown type", 0, 5, 3, 32'h1234_5678, 3);
    check("R1 count held", free_cnt_o, 0);
    send("R4 body after error", 1, 2, 1, 32'hB000_0003, 1);
    check("R7 err sticky", err_o, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_alloc();
    t_release();
    t_full();
    t_error();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule